// File: doc/BRIEF.md
# ADC Conversion Control and Status Register

This block is the software-visible control word of an analog-to-digital conversion sequencer. A CPU writes it through a byte-lane write port to pick the hardware trigger sources, enable the completion interrupt, start a conversion or cut one short. The block sends start and abort commands to the converter core. It watches the core's conversion-done pulse and, when a result may be kept, raises a latch enable for the external result register. It then sets a completion flag and drives an interrupt or DMA request from that flag.

There is only one result register, and a DMA engine drains it. When a second result arrives before the DMA has taken the first one, the block does not latch the new result. It raises a pause flag and a hold output that freezes the core. When the DMA-done pulse arrives, the block latches the waiting result in that same cycle. A read that is part of a read-modify-write always shows the busy bit as 1. A read-back-and-rewrite therefore never aborts a running conversion by accident.

The mode input selects single conversion (value 0) or repeating conversion (values 1 to 3, which cover continuous and stop modes). The block only needs to know whether busy clears by itself.

Top module: `adc_csr`

## Requirements
- R1: After reset, busy, completion flag, interrupt enable, pause and both trigger-select bits are 0. The read value is 0x0000 and every command and request output is low.
- R2: Read-back layout of the upper byte, from bit 15 down: busy, completion flag, interrupt enable, pause, trigger select bit 1, trigger select bit 0, start (always reads 0), reserved (reads 0). The lower byte reads 0. Interrupt enable and trigger select load from any write with byte strobe 1 set. A write with strobe 1 clear changes nothing.
- R3: A start is taken when the block is idle and one of two things happens. Either a strobe-1 write has bit 15 = 1 and bit 9 = 1, or a hardware trigger line hwTrig[i] pulses while trigger select bit i is 1. In that cycle startCmd is high, and busy is 1 from the next cycle.
- R4: While busy is 1, no start request of any kind produces startCmd.
- R5: A strobe-1 write with bit 15 = 0 while busy aborts the conversion. abortCmd is high in that cycle, and from the next cycle busy and pause are 0. If bit 9 is also 1 in that write, no start is issued.
- R6: In single mode (mode 0), busy clears in the cycle after the result is latched.
- R7: In modes 1 to 3, busy stays 1 after a result is latched, until an abort write clears it.
- R8: While rdRmw is high, read bit 15 is 1 whatever the busy state.
- R9: A convDone pulse while busy, not paused and not blocked raises latchEn in that cycle and sets the completion flag. A convDone pulse while idle is ignored.
- R10: irq is the flag AND the interrupt enable when dmaEn is 0. dmaReq is the same AND when dmaEn is 1. The two are never high together.
- R11: A write of 0 to the completion flag clears it only while busy is 0. Writing 1 to the completion flag or to pause has no effect.
- R12: With dmaEn = 1 and the flag still set, a convDone pulse does not latch. It sets pause and convHold from the next cycle. Further convDone pulses while paused are ignored.
- R13: With dmaEn = 1, a dmaDone pulse clears the flag. If pause is set, it also raises latchEn in that cycle, clears pause and leaves the flag set. With dmaEn = 0, dmaDone is ignored.
- R14: convDone and dmaDone arriving in the same cycle with the flag set and dmaEn = 1 latch the new result without a stall, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | CPU write strobe |
| wrStrb | input | 2 | Byte-lane enables of the write |
| wrData | input | 16 | Write data |
| rdRmw | input | 1 | Current read belongs to a read-modify-write |
| rdData | output | 16 | Register read value |
| convMode | input | 2 | 0 single, 1 to 3 repeating |
| dmaEn | input | 1 | Results are drained by DMA |
| hwTrig | input | 2 | Hardware trigger pulses |
| convDone | input | 1 | Conversion finished pulse from core |
| dmaDone | input | 1 | DMA transfer finished pulse |
| startCmd | output | 1 | Start pulse to core |
| abortCmd | output | 1 | Forced stop pulse to core |
| latchEn | output | 1 | Load enable for the result register |
| convHold | output | 1 | Hold the core while a result waits |
| irq | output | 1 | Completion interrupt request |
| dmaReq | output | 1 | DMA transfer request |

## Verification
The drain of the result register and the arrival of a new result can land in the same cycle: dmaDone and convDone pulse together while the flag is set. The bench drives both in one cycle on purpose. It expects latchEn in that cycle with no pause, and the flag still set afterwards. An abort write with the start bit set during a conversion is also driven. There the bench expects abortCmd alone.

// File: rtl/adc_csr_pkg.sv
package adc_csr_pkg;
  localparam int STS_W    = 2;
  localparam int B_BUSY   = 7;
  localparam int B_FLAG   = 6;
  localparam int B_INTE   = 5;
  localparam int B_PAUSE  = 4;
  localparam int B_STS_LO = 2;
  localparam int B_STRT   = 1;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_CONT   = 2'b01,
    MODE_STOP   = 2'b10,
    MODE_STOP2  = 2'b11
  } convMode_e;

  typedef struct packed {
    logic setBusy;
    logic clrBusy;
    logic setFlag;
    logic clrFlag;
    logic setPause;
    logic clrPause;
    logic loadCfg;
  } csrStrobe_t;
endpackage

// File: rtl/adc_csr_ctrl.sv
module adc_csr_ctrl
  import adc_csr_pkg::*;
(
  input  logic             csrWr,
  input  logic [7:0]       csrByte,
  input  logic             singleMode,
  input  logic             dmaEn,
  input  logic [STS_W-1:0] hwTrig,
  input  logic             convDone,
  input  logic             dmaDone,
  input  logic             busyQ,
  input  logic             flagQ,
  input  logic             inteQ,
  input  logic             pauseQ,
  input  logic [STS_W-1:0] stsQ,
  output csrStrobe_t       strobe,
  output logic             startCmd,
  output logic             abortCmd,
  output logic             latchEn,
  output logic             irq,
  output logic             dmaReq
);
  logic abortReq, swStart, hwStart, drainNow, blocked, freshLatch, stall, resume;

  always_comb begin
    abortReq   = csrWr & ~csrByte[B_BUSY];
    swStart    = csrWr & csrByte[B_BUSY] & csrByte[B_STRT];
    hwStart    = |(hwTrig & stsQ);
    startCmd   = ~busyQ & ~abortReq & (swStart | hwStart);
    abortCmd   = abortReq & busyQ;
    drainNow   = dmaEn & dmaDone;
    blocked    = dmaEn & flagQ & ~dmaDone;
    freshLatch = busyQ & ~pauseQ & convDone & ~blocked;
    stall      = busyQ & ~pauseQ & convDone & blocked;
    resume     = pauseQ & drainNow;
    latchEn    = ~abortCmd & (freshLatch | resume);

    strobe.setBusy  = startCmd;
    strobe.clrBusy  = abortCmd | (latchEn & singleMode);
    strobe.setFlag  = latchEn;
    strobe.clrFlag  = drainNow | (csrWr & ~csrByte[B_FLAG] & ~busyQ);
    strobe.setPause = stall & ~abortCmd;
    strobe.clrPause = abortCmd | resume;
    strobe.loadCfg  = csrWr;

    irq    = flagQ & inteQ & ~dmaEn;
    dmaReq = flagQ & inteQ & dmaEn;
  end
endmodule

// File: rtl/adc_csr_dp.sv
module adc_csr_dp
  import adc_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  csrStrobe_t       strobe,
  input  logic [7:0]       cfgByte,
  output logic             busyQ,
  output logic             flagQ,
  output logic             inteQ,
  output logic             pauseQ,
  output logic [STS_W-1:0] stsQ,
  output logic [7:0]       viewByte
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      flagQ  <= 1'b0;
      inteQ  <= 1'b0;
      pauseQ <= 1'b0;
      stsQ   <= '0;
    end else begin
      if (strobe.setBusy)      busyQ <= 1'b1;
      else if (strobe.clrBusy) busyQ <= 1'b0;

      if (strobe.setFlag)      flagQ <= 1'b1;
      else if (strobe.clrFlag) flagQ <= 1'b0;

      if (strobe.clrPause)      pauseQ <= 1'b0;
      else if (strobe.setPause) pauseQ <= 1'b1;

      if (strobe.loadCfg) begin
        inteQ <= cfgByte[B_INTE];
        stsQ  <= cfgByte[B_STS_LO +: STS_W];
      end
    end
  end

  always_comb begin
    viewByte = '0;
    viewByte[B_BUSY]  = busyQ;
    viewByte[B_FLAG]  = flagQ;
    viewByte[B_INTE]  = inteQ;
    viewByte[B_PAUSE] = pauseQ;
    viewByte[B_STS_LO +: STS_W] = stsQ;
  end
endmodule

// File: rtl/adc_csr.sv
module adc_csr
  import adc_csr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CSR_LANE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W/8-1:0] wrStrb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdRmw,
  output logic [DATA_W-1:0] rdData,
  input  logic [1:0]        convMode,
  input  logic              dmaEn,
  input  logic [STS_W-1:0]  hwTrig,
  input  logic              convDone,
  input  logic              dmaDone,
  output logic              startCmd,
  output logic              abortCmd,
  output logic              latchEn,
  output logic              convHold,
  output logic              irq,
  output logic              dmaReq
);
  localparam int LANES = DATA_W / 8;

  csrStrobe_t       strobe;
  logic             busyQ, flagQ, inteQ, pauseQ;
  logic [STS_W-1:0] stsQ;
  logic [7:0]       viewByte;
  logic [7:0]       csrByte;
  logic             csrWr;

  assign csrByte  = wrData[CSR_LANE*8 +: 8];
  assign csrWr    = wrEn & wrStrb[CSR_LANE];
  assign convHold = pauseQ;

  adc_csr_ctrl u_ctrl (
    .csrWr     (csrWr),
    .csrByte   (csrByte),
    .singleMode(convMode == MODE_SINGLE),
    .dmaEn     (dmaEn),
    .hwTrig    (hwTrig),
    .convDone  (convDone),
    .dmaDone   (dmaDone),
    .busyQ     (busyQ),
    .flagQ     (flagQ),
    .inteQ     (inteQ),
    .pauseQ    (pauseQ),
    .stsQ      (stsQ),
    .strobe    (strobe),
    .startCmd  (startCmd),
    .abortCmd  (abortCmd),
    .latchEn   (latchEn),
    .irq       (irq),
    .dmaReq    (dmaReq)
  );

  adc_csr_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgByte (csrByte),
    .busyQ   (busyQ),
    .flagQ   (flagQ),
    .inteQ   (inteQ),
    .pauseQ  (pauseQ),
    .stsQ    (stsQ),
    .viewByte(viewByte)
  );

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    if (lane == CSR_LANE) begin : g_csr
      assign rdData[lane*8 +: 8] = viewByte | {rdRmw, 7'b0};
    end else begin : g_zero
      assign rdData[lane*8 +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/adc_csr_chk.sv
module adc_csr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rdRmw,
  input logic [15:0] rdData,
  input logic [1:0]  convMode,
  input logic        dmaDone,
  input logic        startCmd,
  input logic        abortCmd,
  input logic        latchEn,
  input logic        irq,
  input logic        dmaReq,
  input logic        busyQ,
  input logic        flagQ,
  input logic        pauseQ
);
  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    startCmd |=> busyQ);
  assert_no_start_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !startCmd);
  assert_abort_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    abortCmd |=> (!busyQ && !pauseQ));
  assert_abort_no_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(abortCmd && startCmd));
  assert_single_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (latchEn && convMode == 2'b00) |=> !busyQ);
  assert_repeat_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && convMode != 2'b00 && !abortCmd) |=> busyQ);
  assert_rmw_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdRmw |-> rdData[15]);
  assert_latch_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |=> flagQ);
  assert_req_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(irq && dmaReq));
  assert_stall_no_latch_R12: assert property (@(posedge clk) disable iff (!rstN)
    (pauseQ && !dmaDone) |-> !latchEn);
endmodule

bind adc_csr adc_csr_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .rdRmw   (rdRmw),
  .rdData  (rdData),
  .convMode(convMode),
  .dmaDone (dmaDone),
  .startCmd(startCmd),
  .abortCmd(abortCmd),
  .latchEn (latchEn),
  .irq     (irq),
  .dmaReq  (dmaReq),
  .busyQ   (busyQ),
  .flagQ   (flagQ),
  .pauseQ  (pauseQ)
);

// File: tb/adc_csr_bench.sv
`timescale 1ns/1ps
module adc_csr_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrStrb = 2'b00;
  logic [15:0] wrData = 16'h0;
  logic        rdRmw = 1'b0;
  logic [15:0] rdData;
  logic [1:0]  convMode = 2'b00;
  logic        dmaEn = 1'b0;
  logic [1:0]  hwTrig = 2'b00;
  logic        convDone = 1'b0;
  logic        dmaDone = 1'b0;
  logic        startCmd, abortCmd, latchEn, convHold, irq, dmaReq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference state
  bit mBusy, mFlag, mInte, mPause;
  bit [1:0] mSts;
  // outputs observed in the last cycle
  logic [15:0] oRd;
  logic oStart, oAbort, oLatch, oHold, oIrq, oDma;

  always #2 clk = ~clk;

  adc_csr u_adc_csr (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrStrb(wrStrb), .wrData(wrData),
    .rdRmw(rdRmw), .rdData(rdData), .convMode(convMode), .dmaEn(dmaEn),
    .hwTrig(hwTrig), .convDone(convDone), .dmaDone(dmaDone),
    .startCmd(startCmd), .abortCmd(abortCmd), .latchEn(latchEn),
    .convHold(convHold), .irq(irq), .dmaReq(dmaReq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: sample, compare with model, advance model, clear pulses
  task automatic cyc();
    bit wr, abortReq, swGo, go, kill, drain, waiting, fresh, hold, resume, take;
    logic [15:0] eRd;
    bit eIrq, eDma;
    #1;
    oRd = rdData; oStart = startCmd; oAbort = abortCmd; oLatch = latchEn;
    oHold = convHold; oIrq = irq; oDma = dmaReq;
    wr       = wrEn && wrStrb[1];
    abortReq = wr && !wrData[15];
    swGo     = wr && wrData[15] && wrData[9];
    go       = !mBusy && !abortReq && (swGo || (hwTrig[0] && mSts[0]) || (hwTrig[1] && mSts[1]));
    kill     = abortReq && mBusy;
    drain    = dmaEn && dmaDone;
    waiting  = dmaEn && mFlag && !dmaDone;
    fresh    = mBusy && !mPause && convDone && !waiting;
    hold     = mBusy && !mPause && convDone && waiting && !kill;
    resume   = mPause && drain;
    take     = !kill && (fresh || resume);
    eRd  = {(mBusy || rdRmw), mFlag, mInte, mPause, mSts, 2'b00, 8'h00};
    eIrq = mFlag && mInte && !dmaEn;
    eDma = mFlag && mInte && dmaEn;
    check("MODEL rdData", oRd, eRd);
    check("MODEL strobes", {10'b0, oStart, oAbort, oLatch, oHold, oIrq, oDma},
          {10'b0, go, kill, take, mPause, eIrq, eDma});
    @(posedge clk);
    if (!rstN) begin
      mBusy = 0; mFlag = 0; mInte = 0; mPause = 0; mSts = 0;
    end else begin
      if (take) mFlag = 1;
      else if (drain || (wr && !wrData[14] && !mBusy)) mFlag = 0;
      if (kill || resume) mPause = 0;
      else if (hold) mPause = 1;
      if (go) mBusy = 1;
      else if (kill || (take && convMode == 2'b00)) mBusy = 0;
      if (wr) begin
        mInte = wrData[13];
        mSts  = wrData[11:10];
      end
    end
    @(negedge clk);
    wrEn = 0; wrStrb = 2'b00; wrData = 16'h0; rdRmw = 0;
    hwTrig = 2'b00; convDone = 0; dmaDone = 0;
  endtask

  task automatic wr16(input logic [1:0] strb, input logic [15:0] d);
    wrEn = 1; wrStrb = strb; wrData = d;
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    rstN = 1;
    cyc();
    check("R1 reset read", oRd, 16'h0000);
    check("R1 reset outputs", {10'b0, oStart, oAbort, oLatch, oHold, oIrq, oDma}, 16'h0);

    wr16(2'b10, 16'h2400); cyc();
    check("R2 config readback", oRd, 16'h2400);
    wr16(2'b01, 16'hFFFF); cyc();
    check("R2 low-lane write ignored", oRd, 16'h2400);

    wr16(2'b10, 16'hA600);
    check("R3 software start pulse", {15'b0, oStart}, 16'h1);
    cyc();
    check("R3 busy after start", oRd, 16'hA400);
    wr16(2'b10, 16'hA600);
    check("R4 start ignored while busy", {15'b0, oStart}, 16'h0);

    convDone = 1; cyc();
    check("R9 latch on done", {15'b0, oLatch}, 16'h1);
    cyc();
    check("R6 single mode clears busy", oRd, 16'h6400);
    check("R10 irq without dma", {15'b0, oIrq}, 16'h1);
    convDone = 1; cyc();
    check("R9 done while idle ignored", {15'b0, oLatch}, 16'h0);
    rdRmw = 1; cyc();
    check("R8 rmw sees busy", oRd, 16'hE400);

    wr16(2'b10, 16'h2400); cyc();
    check("R11 flag cleared while idle", oRd, 16'h2400);
    wr16(2'b10, 16'hF400); cyc();
    check("R11 flag/pause writes of 1 ignored", oRd, 16'h2400);

    convMode = 2'b01;
    hwTrig = 2'b10; cyc();
    check("R3 unselected trigger ignored", {15'b0, oStart}, 16'h0);
    hwTrig = 2'b01; cyc();
    check("R3 selected trigger starts", {15'b0, oStart}, 16'h1);
    convDone = 1; cyc(); cyc();
    check("R7 continuous keeps busy", oRd, 16'hE400);
    wr16(2'b10, 16'hA400); cyc();
    check("R11 clear refused while busy", oRd, 16'hE400);
    wr16(2'b10, 16'h2600);
    check("R5 abort with start bit", {14'b0, oAbort, oStart}, 16'h2);
    cyc();
    check("R5 busy cleared by abort", oRd, 16'h6400);
    wr16(2'b10, 16'h2400);

    dmaEn = 1;
    wr16(2'b10, 16'hA600);
    convDone = 1; cyc();
    check("R9 first result latched", {15'b0, oLatch}, 16'h1);
    convDone = 1; cyc();
    check("R10 dma request", {14'b0, oDma, oIrq}, 16'h2);
    check("R12 second result held back", {15'b0, oLatch}, 16'h0);
    convDone = 1; cyc();
    check("R12 paused readback", oRd, 16'hF400);
    check("R12 hold asserted, extra done ignored", {14'b0, oHold, oLatch}, 16'h2);
    dmaDone = 1; cyc();
    check("R13 resume latches", {15'b0, oLatch}, 16'h1);
    cyc();
    check("R13 pause cleared flag kept", oRd, 16'hE400);
    dmaDone = 1; cyc(); cyc();
    check("R13 drain clears flag", oRd, 16'hA400);
    convDone = 1; cyc();
    convDone = 1; dmaDone = 1; cyc();
    check("R14 simultaneous done and drain latch", {15'b0, oLatch}, 16'h1);
    cyc();
    check("R14 no stall, flag set", oRd, 16'hE400);
    dmaEn = 0; dmaDone = 1; cyc(); cyc();
    check("R13 drain ignored without dma", oRd, 16'hE400);
    wr16(2'b10, 16'h2400);
    check("R5 final abort", {15'b0, oAbort}, 16'h1);
    cyc(); cyc();

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule